// File: doc/BRIEF.md
# Reset-Vector Code Segment Unit

This unit keeps the code-segment state of a processor that comes out of reset in real-address mode. The state is a visible 16-bit selector, a hidden 32-bit segment base and a 16-bit instruction pointer. From them the unit forms the 32-bit physical fetch address as base plus pointer. The rest of the front end drives three things: selector loads, pointer writes (jumps) and pointer advances (bytes consumed by fetch).

A hardware reset puts a base into the hidden register that the usual real-mode rule (selector times 16) cannot produce. The pointer is preset at the same time, so the first fetch lands 16 bytes below the top of the 32-bit physical space. That forced base stays in place until software loads a selector for the first time. From then on, every load sets the base from the selector using the normal rule. An output flag reports whether the forced base is still in effect, so the alias can be observed at the ports.

Top module: `rv_code_seg`

## Requirements
- R1: While reset is asserted and after reset is released, the outputs are: selector = F000h, base = FFFF0000h, pointer = FFF0h, override flag = 1.
- R2: The fetch address always equals base plus zero-extended pointer, taken modulo 2^32. Right after reset this gives FFFFFFF0h, which is 16 bytes below the top of the address space.
- R3: When a selector load is strobed, the selector takes the new value on the next edge. The base becomes that value shifted left by 4, with bits 31:20 zero.
- R4: Until the first selector load after reset, the base stays at FFFF0000h, whatever pointer writes or advances occur.
- R5: An advance with no write in the same cycle adds the byte count to the pointer, modulo 2^16, and leaves the base unchanged.
- R6: A pointer write loads the written value. If a write and an advance are strobed in the same cycle, the write wins.
- R7: A selector load and a pointer write in the same cycle both take effect. The following fetch address is new base plus new pointer.
- R8: The override flag stays 1 from reset until the first selector load, then drops to 0. It stays 0 through further loads until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| seg_load | input | 1 | Selector load strobe |
| seg_value | input | 16 | Selector to load |
| ip_wr | input | 1 | Instruction-pointer write strobe |
| ip_wdata | input | 16 | Pointer value to write |
| adv | input | 1 | Fetch-advance strobe |
| adv_bytes | input | ADV_W (4) | Byte count to advance |
| sel_out | output | 16 | Visible selector |
| base_out | output | 32 | Hidden segment base |
| ip_out | output | 16 | Instruction pointer |
| fetch_addr | output | 32 | Physical fetch address |
| boot_alias | output | 1 | 1 while the reset base override is in effect |

## Verification
The bench builds the unit with its default parameters: reset selector F000h, reset base FFFF0000h, reset pointer FFF0h and a 4-bit advance count. With these values, one advance of up to 15 bytes is enough to take the pointer from near FFFFh across the 16-bit wrap, both while the forced base is active and after a real-mode base is in place. The defaults also make the aliased base plus pointer reach FFFFFFFFh exactly. A second reset in the middle of the run brings the override back, which shows that the flag and the base return to their forced values.

// File: rtl/rvcs_pkg.sv
package rvcs_pkg;
  localparam int SEL_W = 16;
  localparam int IP_W  = 16;
  localparam int PA_W  = 32;
  localparam int SHIFT = 4;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [IP_W-1:0]  ip_t;
  typedef logic [PA_W-1:0]  pa_t;

  // Real-mode base: selector scaled by 16, upper bits zero
  function automatic pa_t base_of(sel_t s);
    return pa_t'(s) << SHIFT;
  endfunction

  // Physical fetch address, wraps modulo 2^PA_W
  function automatic pa_t fetch_of(pa_t b, ip_t i);
    return b + pa_t'(i);
  endfunction

  // Pointer advance, wraps modulo 2^IP_W
  function automatic ip_t ip_step(ip_t i, ip_t n);
    return i + n;
  endfunction
endpackage

// File: rtl/rvcs_seg_reg.sv
module rvcs_seg_reg
  import rvcs_pkg::*;
#(
  parameter sel_t RESET_SEL  = 16'hF000,
  parameter pa_t  RESET_BASE = 32'hFFFF_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_load,
  input  sel_t seg_value,
  output sel_t sel_q,
  output pa_t  base_q,
  output logic alias_q
);
  logic load_evt;
  logic first_load;
  assign load_evt   = seg_load;
  assign first_load = seg_load & alias_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= RESET_SEL;
      base_q  <= RESET_BASE;
      alias_q <= 1'b1;
    end else if (load_evt) begin
      sel_q   <= seg_value;
      base_q  <= base_of(seg_value);
      alias_q <= 1'b0;
    end
  end

  // R3
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (sel_q == $past(seg_value)) && (base_q[SHIFT-1:0] == '0)
                 && (base_q[PA_W-1:SEL_W+SHIFT] == '0));
  // R4
  hold_alias_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_q && !load_evt) |=> (base_q == RESET_BASE));
  // R8
  alias_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alias_q) |-> $past(first_load));
  // R8
  alias_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_q |=> !alias_q);
endmodule

// File: rtl/rvcs_ip_reg.sv
module rvcs_ip_reg
  import rvcs_pkg::*;
#(
  parameter int  ADV_W    = 4,
  parameter ip_t RESET_IP = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ip_wr,
  input  ip_t              ip_wdata,
  input  logic             adv,
  input  logic [ADV_W-1:0] adv_bytes,
  output ip_t              ip_q
);
  logic wr_evt;
  logic adv_evt;
  assign wr_evt  = ip_wr;
  assign adv_evt = adv & ~ip_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ip_q <= RESET_IP;
    else if (wr_evt)  ip_q <= ip_wdata;
    else if (adv_evt) ip_q <= ip_step(ip_q, ip_t'(adv_bytes));
  end

  // R6
  ip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ip_q == $past(ip_wdata));
  // R5
  ip_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> ip_q == ip_t'($past(ip_q) + ip_t'($past(adv_bytes))));
  // R5
  ip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ip_wr && !adv) |=> $stable(ip_q));
endmodule

// File: rtl/rvcs_fetch_add.sv
module rvcs_fetch_add
  import rvcs_pkg::*;
(
  input  pa_t base,
  input  ip_t ip,
  output pa_t addr
);
  assign addr = fetch_of(base, ip);
endmodule

// File: rtl/rv_code_seg.sv
module rv_code_seg
  import rvcs_pkg::*;
#(
  parameter int   ADV_W      = 4,
  parameter sel_t RESET_SEL  = 16'hF000,
  parameter pa_t  RESET_BASE = 32'hFFFF_0000,
  parameter ip_t  RESET_IP   = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_load,
  input  logic [15:0]      seg_value,
  input  logic             ip_wr,
  input  logic [15:0]      ip_wdata,
  input  logic             adv,
  input  logic [ADV_W-1:0] adv_bytes,
  output logic [15:0]      sel_out,
  output logic [31:0]      base_out,
  output logic [15:0]      ip_out,
  output logic [31:0]      fetch_addr,
  output logic             boot_alias
);
  sel_t sel_w;
  pa_t  base_w;
  ip_t  ip_w;
  pa_t  addr_w;
  logic alias_w;

  rvcs_seg_reg #(.RESET_SEL(RESET_SEL), .RESET_BASE(RESET_BASE)) u_seg (
    .clk(clk), .rst_n(rst_n), .seg_load(seg_load), .seg_value(seg_value),
    .sel_q(sel_w), .base_q(base_w), .alias_q(alias_w)
  );

  rvcs_ip_reg #(.ADV_W(ADV_W), .RESET_IP(RESET_IP)) u_ip (
    .clk(clk), .rst_n(rst_n), .ip_wr(ip_wr), .ip_wdata(ip_wdata),
    .adv(adv), .adv_bytes(adv_bytes), .ip_q(ip_w)
  );

  rvcs_fetch_add u_add (.base(base_w), .ip(ip_w), .addr(addr_w));

  assign sel_out    = sel_w;
  assign base_out   = base_w;
  assign ip_out     = ip_w;
  assign fetch_addr = addr_w;
  assign boot_alias = alias_w;

  // R4
  alias_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alias_w |-> fetch_addr[PA_W-1:IP_W] == RESET_BASE[PA_W-1:IP_W]);
  // R7
  joint_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_load && ip_wr) |=> fetch_addr[IP_W-1:0] == ip_t'($past(ip_wdata) + ip_t'({$past(seg_value), 4'h0})));
endmodule

// File: tb/tb_rv_code_seg.sv
module tb_rv_code_seg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_load = 1'b0;
  logic [15:0] seg_value = '0;
  logic        ip_wr = 1'b0;
  logic [15:0] ip_wdata = '0;
  logic        adv = 1'b0;
  logic [3:0]  adv_bytes = '0;
  logic [15:0] sel_out;
  logic [31:0] base_out;
  logic [15:0] ip_out;
  logic [31:0] fetch_addr;
  logic        boot_alias;

  always #5 clk = ~clk;

  rv_code_seg dut (
    .clk(clk), .rst_n(rst_n), .seg_load(seg_load), .seg_value(seg_value),
    .ip_wr(ip_wr), .ip_wdata(ip_wdata), .adv(adv), .adv_bytes(adv_bytes),
    .sel_out(sel_out), .base_out(base_out), .ip_out(ip_out),
    .fetch_addr(fetch_addr), .boot_alias(boot_alias)
  );

  typedef struct {
    logic [15:0] sel;
    logic [31:0] base;
    logic [15:0] ip;
    logic [31:0] fa;
    logic        al;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [15:0] m_sel;
  logic [31:0] m_base;
  logic [15:0] m_ip;
  logic        m_al;

  function automatic logic [31:0] model_fa(logic [31:0] b, logic [15:0] i);
    longint s;
    s = longint'(b) + longint'(i);
    return s[31:0];
  endfunction

  task automatic model_reset();
    m_sel = 16'hF000; m_base = 32'hFFFF0000; m_ip = 16'hFFF0; m_al = 1'b1;
  endtask

  task automatic push(string tag);
    exp_t e;
    e.sel = m_sel; e.base = m_base; e.ip = m_ip;
    e.fa = model_fa(m_base, m_ip); e.al = m_al; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic sl, input logic [15:0] sv, input logic iw,
                       input logic [15:0] iwd, input logic ad, input logic [3:0] ab,
                       input string tag);
    @(negedge clk);
    seg_load = sl; seg_value = sv; ip_wr = iw; ip_wdata = iwd; adv = ad; adv_bytes = ab;
    if (sl) begin
      m_sel = sv; m_base = 32'(sv) * 32'd16; m_al = 1'b0;
    end
    if (iw) m_ip = iwd;
    else if (ad) m_ip = 16'((int'(m_ip) + int'(ab)) % 65536);
    push(tag);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 4'h0, tag);
  endtask

  // Monitor: compares each expected item shortly after the edge it belongs to
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sel_out !== e.sel || base_out !== e.base || ip_out !== e.ip ||
          fetch_addr !== e.fa || boot_alias !== e.al) begin
        errors++;
        $display("FAIL %s: got sel=%h base=%h ip=%h fa=%h alias=%b exp sel=%h base=%h ip=%h fa=%h alias=%b",
                 e.tag, sel_out, base_out, ip_out, fetch_addr, boot_alias,
                 e.sel, e.base, e.ip, e.fa, e.al);
      end
    end
  end

  task automatic direct_reset_check();
    checks++;
    if (sel_out !== 16'hF000 || base_out !== 32'hFFFF0000 || ip_out !== 16'hFFF0 ||
        fetch_addr !== 32'hFFFFFFF0 || boot_alias !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: got sel=%h base=%h ip=%h fa=%h alias=%b exp F000 FFFF0000 FFF0 FFFFFFF0 1",
               sel_out, base_out, ip_out, fetch_addr, boot_alias);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    direct_reset_check();                                  // R1
    rst_n = 1'b1;
    idle("R1 R2 reset state, fetch FFFFFFF0");
    drive(0, 0, 0, 0, 1, 4'd4, "R4 advance keeps aliased base");
    drive(0, 0, 1, 16'h1234, 0, 0, "R4 R6 write keeps aliased base");
    drive(0, 0, 1, 16'hFFFE, 1, 4'd9, "R6 write wins over advance");
    drive(0, 0, 0, 0, 1, 4'd3, "R5 wrap under alias");
    drive(0, 0, 1, 16'hFFF0, 0, 0, "R6 write");
    drive(0, 0, 0, 0, 1, 4'd15, "R2 fetch reaches FFFFFFFF");
    idle("R8 flag still set before any load");
    drive(1, 16'h1000, 1, 16'h0100, 0, 0, "R7 load and write together");
    drive(1, 16'hF000, 0, 0, 0, 0, "R3 reload F000 gives F0000");
    idle("R8 flag stays clear");
    drive(1, 16'hFFFF, 0, 0, 1, 4'd15, "R3 load FFFF with advance");
    drive(0, 0, 1, 16'hFFF8, 0, 0, "R6 write after load");
    drive(0, 0, 0, 0, 1, 4'd15, "R5 wrap keeps real-mode base");
    drive(1, 16'h0000, 0, 0, 0, 0, "R3 load zero selector");
    idle("R2 fetch equals pointer at base zero");
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    direct_reset_check();                                  // R1 second reset
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 R8 override back after reset");
    drive(0, 0, 0, 0, 1, 4'd15, "R5 advance after second reset");
    drive(1, 16'h0ABC, 0, 0, 0, 0, "R3 R8 first load after second reset");
    idle("R8 clear after load");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule